// File: doc/BRIEF.md
# Addressing-Byte Effective Address Decoder

This block sits behind an instruction byte stream and handles only the bytes that describe where an instruction's operands are. It receives one byte per clock on a valid strobe. The first byte carries a 2-bit mode, a 3-bit register-operand number and a 3-bit operand selector. Depending on these fields, it may take a scaled-index byte and then a 1-byte or 4-byte displacement. The block reads general registers through two asynchronous register file read ports. It reports either that the second operand is a register, with that register's number, or a finished effective address. In both cases it also gives the number of addressing bytes it consumed.

Results appear as a one-cycle `done` pulse in the clock after the final addressing byte. The decoder is already waiting for a new first byte in that same cycle, so instructions can be fed back to back with no idle clock.

Top module: `ea_byte_decoder`

## Requirements
- R1: A synchronous active-low reset returns the decoder to waiting for a first byte and holds `done` low. This applies even when reset arrives in the middle of an instruction.
- R2: A first byte with mode bits [7:6] = 11 gives, one cycle later, `done`=1, `is_reg`=1, `rm_reg` = bits [2:0] of that byte, `ea`=0 and `byte_count`=1.
- R3: On every `done`, `reg_op` equals bits [5:3] of that instruction's first byte.
- R4: Mode 00 with selector bits [2:0] not equal to 100 gives `ea` = register[selector] and `byte_count`=1.
- R5: Mode 01 adds the next byte, sign-extended to 32 bits, to the base. Without a scaled-index byte, `byte_count`=2.
- R6: Mode 10 adds a 32-bit displacement whose four bytes arrive least-significant first. Without a scaled-index byte, `byte_count`=5.
- R7: In modes 00, 01 and 10, selector 100 means a second byte follows. That byte holds scale in bits [7:6], index in bits [5:3] and base in bits [2:0]. The address is then register[base] + (register[index] << scale) + displacement, and `byte_count` is 2, 3 or 6 for modes 00, 01 and 10.
- R8: An index field of 100 in the second byte contributes zero, whatever the scale.
- R9: Cycles with `byte_valid` low change nothing: any byte presented in them is ignored and `done` stays low.
- R10: The cycle in which `done` is high also accepts a new first byte, so instructions can follow one another with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | `byte_in` carries an addressing byte this cycle |
| byte_in | input | 8 | Addressing byte |
| rf_base_sel | output | 3 | Register file read address for the base register (always `byte_in[2:0]`) |
| rf_base_data | input | AW (32) | Contents of register `rf_base_sel`, same cycle |
| rf_index_sel | output | 3 | Register file read address for the index register (always `byte_in[5:3]`) |
| rf_index_data | input | AW (32) | Contents of register `rf_index_sel`, same cycle |
| done | output | 1 | One-cycle pulse: result fields are valid |
| is_reg | output | 1 | Second operand is a register, not memory |
| rm_reg | output | 3 | Register number of the second operand when `is_reg` |
| reg_op | output | 3 | Register number of the always-register operand |
| ea | output | AW (32) | Effective address (0 for a register operand) |
| byte_count | output | CW (3) | Addressing bytes consumed by this instruction |

## Verification
The bound assertions check several rules on every clock:
- a register-mode first byte produces a register result with count 1 in the next cycle;
- a plain mode-00 first byte returns the base register unchanged;
- an invalid cycle changes neither state nor `done`;
- a result count is always one of the legal lengths;
- the decoder is ready for a new first byte whenever it reports.

Only the bench's scenarios can show the rest. This covers the arithmetic of the scaled index and of both displacement sizes, the byte order of the wide displacement, and the rule that index 100 is ignored. It also covers the `reg_op` field, the recovery from a reset in the middle of an instruction, and correct decoding when gaps appear inside an instruction.

// File: rtl/ea_pkg.sv
// Package: shared decoder state type and field codes.
// Assumes 8-bit addressing bytes with 2/3/3 field splits.
package ea_pkg;
    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,   // waiting for the mode/register/selector byte
        ST_SCIDX = 2'd1,   // waiting for the scale/index/base byte
        ST_DISP  = 2'd2    // collecting displacement bytes
    } ea_state_t;

    localparam logic [1:0] MODE_NODISP = 2'b00;
    localparam logic [1:0] MODE_DISP8  = 2'b01;
    localparam logic [1:0] MODE_DISP32 = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;
    localparam logic [2:0] SEL_ESCAPE  = 3'b100;  // selector: scaled-index byte follows
    localparam logic [2:0] IDX_NONE    = 3'b100;  // index field: no index
endpackage

// File: rtl/ea_scaled_index.sv
// Module: scales an index register value by 2**scale.
// Assumes a 3-bit index code; code IDX_NONE yields zero.
module ea_scaled_index #(
    parameter int AW = 32
) (
    input  logic [2:0]    idx_code,
    input  logic [1:0]    scale,
    input  logic [AW-1:0] idx_data,
    output logic [AW-1:0] scaled
);
    import ea_pkg::*;

    // Purpose: drop the index when absent, otherwise shift by scale.
    always_comb begin
        if (idx_code == IDX_NONE) scaled = '0;
        else                      scaled = idx_data << scale;
    end
endmodule

// File: rtl/ea_disp_collector.sv
// Module: gathers displacement bytes, least significant first, and
// forms the sign-extended narrow or full-width displacement using the
// byte presented in the current cycle as the last one.
// Assumes AW is a multiple of 8 and NB = AW/8 >= 2.
module ea_disp_collector #(
    parameter int AW = 32,
    parameter int NB = AW / 8,
    parameter int PW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [PW-1:0] pos,
    input  logic [7:0]    byte_in,
    input  logic          wide,
    output logic [AW-1:0] disp_ext
);
    logic [7:0] low_q [NB-1];
    logic [AW-1:0] wide_val;

    for (genvar g = 0; g < NB - 1; g++) begin : g_low
        // Purpose: store byte g of the wide displacement.
        always_ff @(posedge clk) begin
            if (!rst_n)                                low_q[g] <= '0;
            else if (take && pos == PW'(g))            low_q[g] <= byte_in;
        end
    end

    // Purpose: assemble the stored low bytes with the current top byte.
    always_comb begin
        wide_val = '0;
        for (int i = 0; i < NB - 1; i++) wide_val[8*i +: 8] = low_q[i];
        wide_val[8*(NB-1) +: 8] = byte_in;
    end

    // Purpose: choose the full-width or the sign-extended single byte.
    always_comb begin
        if (wide) disp_ext = wide_val;
        else      disp_ext = {{(AW-8){byte_in[7]}}, byte_in};
    end
endmodule

// File: rtl/ea_byte_decoder.sv
// Module: byte-serial decoder of operand addressing bytes.
// Consumes one byte per valid cycle: first byte, optional scaled-index
// byte, optional 1- or AW/8-byte displacement. Reads registers through
// two asynchronous read ports addressed straight from byte_in. Reports a
// one-cycle done pulse the cycle after the final byte and is ready for
// a new first byte in that same cycle.
module ea_byte_decoder #(
    parameter int AW = 32,
    parameter int NB = AW / 8,
    parameter int PW = $clog2(NB),
    parameter int CW = $clog2(NB + 3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    output logic [2:0]    rf_base_sel,
    input  logic [AW-1:0] rf_base_data,
    output logic [2:0]    rf_index_sel,
    input  logic [AW-1:0] rf_index_data,
    output logic          done,
    output logic          is_reg,
    output logic [2:0]    rm_reg,
    output logic [2:0]    reg_op,
    output logic [AW-1:0] ea,
    output logic [CW-1:0] byte_count
);
    import ea_pkg::*;

    ea_state_t     state_q;
    logic [1:0]    mode_q;
    logic [2:0]    reg_q;
    logic [2:0]    rm_q;
    logic [AW-1:0] partial_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] dpos_q;

    logic [AW-1:0] scaled;
    logic [AW-1:0] disp_ext;
    logic          disp_last;

    logic          done_q, is_reg_q;
    logic [2:0]    rm_reg_q, reg_op_q;
    logic [AW-1:0] ea_q;
    logic [CW-1:0] count_q;

    // Purpose: base and selector share bits [2:0]; index sits in [5:3].
    assign rf_base_sel  = byte_in[2:0];
    assign rf_index_sel = byte_in[5:3];

    ea_scaled_index #(.AW(AW)) u_scale (
        .idx_code (byte_in[5:3]),
        .scale    (byte_in[7:6]),
        .idx_data (rf_index_data),
        .scaled   (scaled)
    );

    ea_disp_collector #(.AW(AW), .NB(NB), .PW(PW)) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (byte_valid && state_q == ST_DISP),
        .pos      (dpos_q),
        .byte_in  (byte_in),
        .wide     (mode_q == MODE_DISP32),
        .disp_ext (disp_ext)
    );

    // Purpose: flag the final displacement byte for the current mode.
    assign disp_last = (mode_q == MODE_DISP8) || (dpos_q == PW'(NB - 1));

    // Purpose: sequence through the addressing bytes and register results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_FIRST;
            mode_q    <= '0;
            reg_q     <= '0;
            rm_q      <= '0;
            partial_q <= '0;
            cnt_q     <= '0;
            dpos_q    <= '0;
            done_q    <= 1'b0;
            is_reg_q  <= 1'b0;
            rm_reg_q  <= '0;
            reg_op_q  <= '0;
            ea_q      <= '0;
            count_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (byte_valid) begin
                unique case (state_q)
                    ST_FIRST: begin
                        mode_q <= byte_in[7:6];
                        reg_q  <= byte_in[5:3];
                        rm_q   <= byte_in[2:0];
                        cnt_q  <= CW'(1);
                        dpos_q <= '0;
                        if (byte_in[7:6] == MODE_REG) begin
                            done_q   <= 1'b1;
                            is_reg_q <= 1'b1;
                            rm_reg_q <= byte_in[2:0];
                            reg_op_q <= byte_in[5:3];
                            ea_q     <= '0;
                            count_q  <= CW'(1);
                        end else if (byte_in[2:0] == SEL_ESCAPE) begin
                            state_q <= ST_SCIDX;
                        end else if (byte_in[7:6] == MODE_NODISP) begin
                            done_q   <= 1'b1;
                            is_reg_q <= 1'b0;
                            rm_reg_q <= byte_in[2:0];
                            reg_op_q <= byte_in[5:3];
                            ea_q     <= rf_base_data;
                            count_q  <= CW'(1);
                        end else begin
                            partial_q <= rf_base_data;
                            state_q   <= ST_DISP;
                        end
                    end
                    ST_SCIDX: begin
                        cnt_q <= CW'(2);
                        if (mode_q == MODE_NODISP) begin
                            done_q   <= 1'b1;
                            is_reg_q <= 1'b0;
                            rm_reg_q <= rm_q;
                            reg_op_q <= reg_q;
                            ea_q     <= rf_base_data + scaled;
                            count_q  <= CW'(2);
                            state_q  <= ST_FIRST;
                        end else begin
                            partial_q <= rf_base_data + scaled;
                            state_q   <= ST_DISP;
                        end
                    end
                    ST_DISP: begin
                        cnt_q  <= cnt_q + CW'(1);
                        dpos_q <= dpos_q + PW'(1);
                        if (disp_last) begin
                            done_q   <= 1'b1;
                            is_reg_q <= 1'b0;
                            rm_reg_q <= rm_q;
                            reg_op_q <= reg_q;
                            ea_q     <= partial_q + disp_ext;
                            count_q  <= cnt_q + CW'(1);
                            state_q  <= ST_FIRST;
                        end
                    end
                    default: state_q <= ST_FIRST;
                endcase
            end
        end
    end

    assign done       = done_q;
    assign is_reg     = is_reg_q;
    assign rm_reg     = rm_reg_q;
    assign reg_op     = reg_op_q;
    assign ea         = ea_q;
    assign byte_count = count_q;
endmodule

// File: rtl/ea_byte_decoder_chk.sv
// Module: temporal checks on the decoder, attached by bind below.
// Assumes access to the decoder's state register.
module ea_byte_decoder_chk #(
    parameter int AW = 32,
    parameter int CW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic [7:0]        byte_in,
    input ea_pkg::ea_state_t state_q,
    input logic              done,
    input logic              is_reg,
    input logic [2:0]        rm_reg,
    input logic [AW-1:0]     ea,
    input logic [AW-1:0]     rf_base_data,
    input logic [CW-1:0]     byte_count
);
    import ea_pkg::*;

    // R1: reset leaves the decoder idle with no result
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_FIRST && !done));

    // R2: register-mode first byte reports at once
    a_r2_reg_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && byte_valid && byte_in[7:6] == MODE_REG)
        |=> (done && is_reg && byte_count == CW'(1) && rm_reg == $past(byte_in[2:0])));

    // R4: plain base addressing returns the base register
    a_r4_plain_base: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && byte_valid && byte_in[7:6] == MODE_NODISP
         && byte_in[2:0] != SEL_ESCAPE)
        |=> (done && !is_reg && ea == $past(rf_base_data) && byte_count == CW'(1)));

    // R7: reported length is one of the legal totals
    a_r7_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_count != CW'(0) && byte_count != CW'(4) && byte_count <= CW'(6)));

    // R9: an invalid cycle changes nothing
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> (!done && $stable(state_q)));

    // R10: ready for a new first byte whenever a result is shown
    a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state_q == ST_FIRST);
endmodule

bind ea_byte_decoder ea_byte_decoder_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid   (byte_valid),
    .byte_in      (byte_in),
    .state_q      (state_q),
    .done         (done),
    .is_reg       (is_reg),
    .rm_reg       (rm_reg),
    .ea           (ea),
    .rf_base_data (rf_base_data),
    .byte_count   (byte_count)
);

// File: tb/tb_ea_byte_decoder.sv
// Bench: sweeps every first byte and, where it applies, every
// scaled-index byte, computing addresses arithmetically.
module tb_ea_byte_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [2:0]  rf_base_sel, rf_index_sel;
    logic [31:0] rf_base_data, rf_index_data;
    logic        done, is_reg;
    logic [2:0]  rm_reg, reg_op;
    logic [31:0] ea;
    logic [2:0]  byte_count;

    int checks = 0;
    int errors = 0;
    bit prev_done_open = 1'b0;

    always #5 clk = ~clk;

    // Purpose: register file contents as a pure function of register number.
    function automatic logic [31:0] rfval(input logic [2:0] r);
        return (32'h0101_0101 * (32'(r) + 1)) ^ {r, 29'h0000_0ab5};
    endfunction

    assign rf_base_data  = rfval(rf_base_sel);
    assign rf_index_data = rfval(rf_index_sel);

    ea_byte_decoder dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
        .rf_index_sel(rf_index_sel), .rf_index_data(rf_index_data),
        .done(done), .is_reg(is_reg), .rm_reg(rm_reg), .reg_op(reg_op),
        .ea(ea), .byte_count(byte_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Purpose: feed one instruction's addressing bytes and check the result.
    task automatic run(input logic [7:0] m, input logic [7:0] s,
                       input logic [31:0] d, input bit gaps);
        logic [7:0]  b [6];
        int          n;
        bit          has_sib;
        logic [31:0] exp_ea, base, idx, disp;
        string       req;
        has_sib = (m[7:6] != 2'b11) && (m[2:0] == 3'b100);
        n = 0;
        b[n] = m; n++;
        if (has_sib) begin b[n] = s; n++; end
        if (m[7:6] == 2'b01) begin b[n] = d[7:0]; n++; end
        if (m[7:6] == 2'b10) for (int j = 0; j < 4; j++) begin b[n] = d[8*j +: 8]; n++; end
        base = has_sib ? rfval(s[2:0]) : rfval(m[2:0]);
        idx  = (has_sib && s[5:3] != 3'b100) ? (rfval(s[5:3]) << s[7:6]) : 32'h0;
        disp = (m[7:6] == 2'b01) ? {{24{d[7]}}, d[7:0]} : (m[7:6] == 2'b10) ? d : 32'h0;
        exp_ea = base + idx + disp;
        if (m[7:6] == 2'b11)      req = "R2";
        else if (has_sib)         req = (s[5:3] == 3'b100) ? "R8" : "R7";
        else if (m[7:6] == 2'b00) req = "R4";
        else if (m[7:6] == 2'b01) req = "R5";
        else                      req = "R6";
        for (int i = 0; i < n; i++) begin
            if (i == 0 && prev_done_open)
                chk(done == 1'b1, "R10", "done while next first byte offered", 32'(done), 32'h1);
            if (i > 0)
                chk(done == 1'b0, req, "done mid-instruction", 32'(done), 32'h0);
            byte_valid = 1'b1;
            byte_in    = b[i];
            @(negedge clk);
            if (gaps && i < n - 1) begin
                byte_valid = 1'b0;
                byte_in    = 8'hC3;
                for (int g = 0; g < 2; g++) begin
                    @(negedge clk);
                    chk(done == 1'b0, "R9", "done during gap", 32'(done), 32'h0);
                end
            end
        end
        byte_valid = 1'b0;
        chk(done == 1'b1, req, "done", 32'(done), 32'h1);
        chk(reg_op == m[5:3], "R3", "reg_op", 32'(reg_op), 32'(m[5:3]));
        if (m[7:6] == 2'b11) begin
            chk(is_reg == 1'b1 && rm_reg == m[2:0] && ea == 32'h0 && byte_count == 3'd1,
                req, "register result {is_reg,rm,count}",
                {24'h0, is_reg, rm_reg, 1'b0, byte_count}, {24'h0, 1'b1, m[2:0], 1'b0, 3'd1});
        end else begin
            chk(is_reg == 1'b0, req, "is_reg", 32'(is_reg), 32'h0);
            chk(ea == exp_ea, req, "ea", ea, exp_ea);
            chk(byte_count == 3'(n), req, "byte_count", 32'(byte_count), 32'(n));
        end
        prev_done_open = 1'b1;
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk(done == 1'b0, "R9", "done after idle cycle", 32'(done), 32'h0);
        prev_done_open = 1'b0;
    endtask

    initial begin : main
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'h0);
        for (int mi = 0; mi < 256; mi++) begin
            logic [7:0] m;
            m = 8'(mi);
            if (m[7:6] != 2'b11 && m[2:0] == 3'b100) begin
                if (m[5:3] == 3'b000 || m[5:3] == 3'b101) begin
                    for (int si = 0; si < 256; si++) begin
                        run(m, 8'(si), 32'(k) * 32'h9E37_79B1 ^ 32'h00F0_0F80, (k % 7) == 3);
                        if (k % 5 == 0) idle_check();
                        k++;
                    end
                end else begin
                    run(m, 8'(k * 29), 32'(k) * 32'h9E37_79B1, (k % 7) == 3);
                    k++;
                end
            end else begin
                run(m, 8'h00, 32'(k) * 32'h9E37_79B1 ^ 32'h8000_0080, (k % 7) == 3);
                if (k % 5 == 0) idle_check();
                k++;
            end
        end
        // Disp8 sign corner values (R5).
        run(8'h41, 8'h00, 32'h0000_0080, 1'b0);
        run(8'h42, 8'h00, 32'h0000_007F, 1'b0);
        run(8'h43, 8'h00, 32'h0000_00FF, 1'b0);
        // R1: reset in the middle of a wide-displacement instruction.
        idle_check();
        byte_valid = 1'b1; byte_in = 8'h84; @(negedge clk);
        byte_in = 8'h1A; @(negedge clk);
        byte_in = 8'h11; @(negedge clk);
        byte_in = 8'h22; @(negedge clk);
        byte_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done during mid-instruction reset", 32'(done), 32'h0);
        rst_n = 1'b1;
        run(8'hD5, 8'h00, 32'h0, 1'b0);
        run(8'h03, 8'h00, 32'h0, 1'b0);
        idle_check();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule